// File: doc/BRIEF.md
# Gate Drive Edge Pulse-Train Modulator

This block sits between a PWM command for one power switch and the two switches that connect the gate to its positive and negative drive supplies. In normal running it behaves like a plain driver. A high command connects the positive supply and a low command connects the negative supply. Once a switching-spike flag has been raised, each enabled command edge is preceded by a programmable burst of pulses. The gate voltage then climbs or falls in steps, which slows the switching transient. The steady level is applied only after the burst ends.

Two burst styles are selectable. In bidirectional style, the gaps between pulses connect the opposite supply, so the rails alternate. In unidirectional style, the gaps connect nothing and the gate floats, so the gate voltage never falls back during the ramp. The pulse length, the gap length and the number of pulses are counted in clock cycles. They come from configuration inputs that are captured only while no burst is running. The logic clock is intended to be 40 MHz, with switching at a few kHz.

Top module: `gate_edge_shaper`

## Requirements
- R1: With no burst active, a command sampled high drives only `pos_en` and a command sampled low drives only `neg_en`. A command change sampled at clock edge E1 shows both rails off after edge E2 and the new rail on after edge E3.
- R2: `pos_en` and `neg_en` are never high in the same cycle. Every change from one rail to the other passes through at least one cycle with both low.
- R3: When the flag is armed and the edge direction is enabled, the edge starts a burst at the sampling edge. The burst has `cfg_pulses` repetitions of `cfg_on` cycles driving the target rail followed by `cfg_off` cycles of gap. The steady target rail follows the final gap.
- R4: With `mode_uni`=0 (bidirectional), every burst gap drives the rail opposite to the target.
- R5: With `mode_uni`=1 (unidirectional), every burst gap leaves both rails off. The opposite rail is never driven during the burst.
- R6: `en_rise` enables bursts on low-to-high command edges and `en_fall` enables them on high-to-low edges. An edge whose enable is 0 passes through as in R1.
- R7: `spike_async` passes through a two-stage synchronizer and sets a sticky arm state. `spike_clear` disarms it, and clear wins over a simultaneous set. Unarmed edges pass through as in R1.
- R8: If the command reverses while a burst runs, the burst is abandoned. The new steady rail follows R1 timing with no new burst.
- R9: `cfg_on` and `cfg_off` are captured only while no burst is running. `cfg_pulses` is taken when a burst starts. Changes made during a burst do not alter that burst.
- R10: If any of `cfg_on`, `cfg_off` or `cfg_pulses` is zero when an edge is sampled, that edge passes through as in R1.
- R11: While `rst_n` is low, both rails are off. After release, the first clock edge drives `neg_en`, because the command state resets to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_cmd | input | 1 | Switch command, synchronous to clk |
| spike_async | input | 1 | Asynchronous switching-spike flag |
| spike_clear | input | 1 | Disarms edge shaping |
| mode_uni | input | 1 | 1 = gaps float, 0 = gaps drive opposite rail |
| en_rise | input | 1 | Shape low-to-high edges |
| en_fall | input | 1 | Shape high-to-low edges |
| cfg_on | input | 8 | Pulse length in cycles |
| cfg_off | input | 8 | Gap length in cycles |
| cfg_pulses | input | 8 | Pulses per burst |
| pos_en | output | 1 | Connect positive drive supply |
| neg_en | output | 1 | Connect negative drive supply |

## Verification
The bench counts rail cycles across whole bursts in both styles and both directions. A wrong gap style shows up as opposite-rail cycles where only floating is allowed, or the reverse. A missing idle cycle shows up as a direct rail swap, and an off-by-one in the pulse or gap counters moves the steady rail's arrival cycle. Configuration is rewritten mid-burst and the command is reversed mid-burst. A design that reloads live settings stretches the burst, and one that ignores reversal keeps pulsing the positive rail after the command has dropped. Clearing the arm state and zero-length settings must both return exact pass-through timing.

// File: rtl/gate_shaper_pkg.sv
// Shared types for the gate edge shaper.
package gate_shaper_pkg;
    // Which drive supply the gate should be connected to.
    typedef enum logic [1:0] {
        RAIL_OFF = 2'b00,
        RAIL_POS = 2'b01,
        RAIL_NEG = 2'b10
    } rail_e;

    // Part of a burst pulse period currently being played.
    typedef enum logic {
        PH_PULSE = 1'b0,
        PH_GAP   = 1'b1
    } phase_e;
endpackage

// File: rtl/spike_arm.sv
// Synchronizes the asynchronous spike flag and holds a sticky arm state.
// Assumes SYNC_STAGES >= 2. Clear has priority over a synchronized set.
module spike_arm #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spike_async,
    input  logic spike_clear,
    output logic armed
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Shift the raw flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], spike_async};
    end

    // Sticky arm flag, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     armed <= 1'b0;
        else if (spike_clear)           armed <= 1'b0;
        else if (sync_q[SYNC_STAGES-1]) armed <= 1'b1;
    end
endmodule

// File: rtl/burst_seq.sv
// Detects command edges and plays the pulse burst, producing a rail request.
// Assumes pwm_cmd is synchronous to clk. The pulse count is taken at burst
// start. The pulse and gap lengths are shadowed while idle and reused for
// every pulse of the burst.
module burst_seq
    import gate_shaper_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_cmd,
    input  logic             armed,
    input  logic             mode_uni,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic [CNT_W-1:0] cfg_on,
    input  logic [CNT_W-1:0] cfg_off,
    input  logic [CNT_W-1:0] cfg_pulses,
    output rail_e            req,
    output logic             busy,
    output logic             dir_up,
    output logic             pwm_held
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] on_sh, off_sh, timer, left;
    phase_e           phase;
    logic             edge_seen, want_burst, cfg_ok;
    rail_e            target, opposite;

    assign edge_seen  = (pwm_cmd != pwm_held);
    assign cfg_ok     = (cfg_on != '0) && (cfg_off != '0) && (cfg_pulses != '0);
    assign want_burst = armed && cfg_ok && (pwm_cmd ? en_rise : en_fall);

    // Capture pulse and gap lengths only while no burst runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_sh  <= '0;
            off_sh <= '0;
        end else if (!busy) begin
            on_sh  <= cfg_on;
            off_sh <= cfg_off;
        end
    end

    // Edge handling and burst timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_held <= 1'b0;
            busy     <= 1'b0;
            dir_up   <= 1'b0;
            phase    <= PH_PULSE;
            timer    <= '0;
            left     <= '0;
        end else begin
            pwm_held <= pwm_cmd;
            if (edge_seen) begin
                if (busy) begin
                    busy <= 1'b0;
                end else if (want_burst) begin
                    busy   <= 1'b1;
                    dir_up <= pwm_cmd;
                    phase  <= PH_PULSE;
                    timer  <= cfg_on;
                    left   <= cfg_pulses;
                end
            end else if (busy) begin
                if (timer != ONE) begin
                    timer <= timer - ONE;
                end else if (phase == PH_PULSE) begin
                    phase <= PH_GAP;
                    timer <= off_sh;
                end else if (left == ONE) begin
                    busy <= 1'b0;
                end else begin
                    left  <= left - ONE;
                    phase <= PH_PULSE;
                    timer <= on_sh;
                end
            end
        end
    end

    assign target   = dir_up ? RAIL_POS : RAIL_NEG;
    assign opposite = dir_up ? RAIL_NEG : RAIL_POS;

    // Rail wanted in this cycle, before break-before-make.
    always_comb begin
        if (!busy)                  req = pwm_held ? RAIL_POS : RAIL_NEG;
        else if (phase == PH_PULSE) req = target;
        else if (mode_uni)          req = RAIL_OFF;
        else                        req = opposite;
    end
endmodule

// File: rtl/rail_guard.sv
// Registers the rail request and inserts one all-off cycle whenever the
// request swaps directly between the two supplies.
module rail_guard
    import gate_shaper_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rail_e req,
    output logic  pos_en,
    output logic  neg_en
);
    rail_e cur, nxt;

    // Break-before-make selection.
    always_comb begin
        if ((req == RAIL_POS && cur == RAIL_NEG) ||
            (req == RAIL_NEG && cur == RAIL_POS)) nxt = RAIL_OFF;
        else                                      nxt = req;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= RAIL_OFF;
        else        cur <= nxt;
    end

    assign pos_en = (cur == RAIL_POS);
    assign neg_en = (cur == RAIL_NEG);
endmodule

// File: rtl/gate_edge_shaper.sv
// Top level: spike arming, burst sequencing and rail guarding for one switch.
// Assumes pwm_cmd is synchronous to clk; spike_async may be asynchronous.
module gate_edge_shaper
    import gate_shaper_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_cmd,
    input  logic             spike_async,
    input  logic             spike_clear,
    input  logic             mode_uni,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic [CNT_W-1:0] cfg_on,
    input  logic [CNT_W-1:0] cfg_off,
    input  logic [CNT_W-1:0] cfg_pulses,
    output logic             pos_en,
    output logic             neg_en
);
    logic  armed, burst_busy, burst_dir_up, pwm_held;
    rail_e rail_req;

    spike_arm #(.SYNC_STAGES(SYNC_STAGES)) u_arm (
        .clk(clk), .rst_n(rst_n), .spike_async(spike_async),
        .spike_clear(spike_clear), .armed(armed)
    );

    burst_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .armed(armed),
        .mode_uni(mode_uni), .en_rise(en_rise), .en_fall(en_fall),
        .cfg_on(cfg_on), .cfg_off(cfg_off), .cfg_pulses(cfg_pulses),
        .req(rail_req), .busy(burst_busy), .dir_up(burst_dir_up),
        .pwm_held(pwm_held)
    );

    rail_guard u_guard (
        .clk(clk), .rst_n(rst_n), .req(rail_req),
        .pos_en(pos_en), .neg_en(neg_en)
    );
endmodule

// File: rtl/gate_edge_shaper_chk.sv
// Property checker for the gate edge shaper, bound to the top module.
module gate_edge_shaper_chk (
    input logic clk,
    input logic rst_n,
    input logic pos_en,
    input logic neg_en,
    input logic mode_uni,
    input logic spike_clear,
    input logic busy,
    input logic dir_up,
    input logic pwm_q,
    input logic armed
);
    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(pos_en && neg_en)); // R2
    AST_POS_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) pos_en |=> !neg_en); // R2
    AST_NEG_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) neg_en |=> !pos_en); // R2
    AST_UNI_RISE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) (busy && dir_up && mode_uni) |=> !neg_en); // R5
    AST_UNI_FALL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !dir_up && mode_uni) |=> !pos_en); // R5
    AST_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!busy && pwm_q) |=> !neg_en); // R1
    AST_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !pwm_q) |=> !pos_en); // R1
    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) spike_clear |=> !armed); // R7
endmodule

bind gate_edge_shaper gate_edge_shaper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pos_en(pos_en), .neg_en(neg_en),
    .mode_uni(mode_uni), .spike_clear(spike_clear), .busy(burst_busy),
    .dir_up(burst_dir_up), .pwm_q(pwm_held), .armed(armed)
);

// File: tb/gate_edge_shaper_bench.sv
// Directed bench for the gate edge shaper. Inputs change and outputs are
// sampled at the falling clock edge; sample k is taken after rising edge k.
module gate_edge_shaper_bench;
    logic       clk = 1'b0;
    logic       rst_n, pwm_cmd, spike_async, spike_clear, mode_uni, en_rise, en_fall;
    logic [7:0] cfg_on, cfg_off, cfg_pulses;
    logic       pos_en, neg_en;
    int         checks = 0, fails = 0, cyc = 0;
    logic       pos_s [0:63];
    logic       neg_s [0:63];

    always #5 clk = ~clk;

    gate_edge_shaper u_gate_edge_shaper (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .spike_async(spike_async),
        .spike_clear(spike_clear), .mode_uni(mode_uni), .en_rise(en_rise),
        .en_fall(en_fall), .cfg_on(cfg_on), .cfg_off(cfg_off),
        .cfg_pulses(cfg_pulses), .pos_en(pos_en), .neg_en(neg_en)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic capture(input int lo, input int hi);
        for (int k = lo; k <= hi; k++) begin
            step();
            pos_s[k] = pos_en;
            neg_s[k] = neg_en;
        end
    endtask

    function automatic int cnt_pos(input int lo, input int hi);
        int n = 0;
        for (int k = lo; k <= hi; k++) n += int'(pos_s[k]);
        return n;
    endfunction

    function automatic int cnt_neg(input int lo, input int hi);
        int n = 0;
        for (int k = lo; k <= hi; k++) n += int'(neg_s[k]);
        return n;
    endfunction

    // Move the command without shaping and let it settle.
    task automatic set_level(input logic v);
        logic r = en_rise;
        logic f = en_fall;
        en_rise = 1'b0;
        en_fall = 1'b0;
        pwm_cmd = v;
        repeat (6) step();
        en_rise = r;
        en_fall = f;
    endtask

    task automatic set_cfg(input int on_c, input int off_c, input int n_c);
        cfg_on     = 8'(on_c);
        cfg_off    = 8'(off_c);
        cfg_pulses = 8'(n_c);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R11 pos during reset", int'(pos_en), 0);
        chk("R11 neg during reset", int'(neg_en), 0);
        rst_n = 1'b1;
        capture(1, 1);
        chk("R11 neg after release", int'(neg_s[1]), 1);
    endtask

    task automatic t_pass();
        pwm_cmd = 1'b1;
        capture(1, 3);
        chk("R2 idle on rise pass", int'(pos_s[2]) + int'(neg_s[2]), 0);
        chk("R1 pos on rise pass", int'(pos_s[3]), 1);
        pwm_cmd = 1'b0;
        capture(1, 3);
        chk("R2 idle on fall pass", int'(pos_s[2]) + int'(neg_s[2]), 0);
        chk("R1 neg on fall pass", int'(neg_s[3]), 1);
    endtask

    task automatic t_arm();
        spike_async = 1'b1;
        step();
        spike_async = 1'b0;
        repeat (4) step();
    endtask

    task automatic t_uni_rise();
        set_level(1'b0);
        mode_uni = 1'b1;
        set_cfg(2, 3, 2);
        pwm_cmd = 1'b1;
        capture(1, 12);
        chk("R3 uni rise pos cycles", cnt_pos(2, 11), 3);
        chk("R5 uni rise neg cycles", cnt_neg(2, 11), 0);
        chk("R5 uni gap floats", int'(pos_s[5]) + int'(neg_s[5]), 0);
        chk("R3 uni rise steady", int'(pos_s[12]), 1);
    endtask

    task automatic t_cfg_hold();
        set_level(1'b0);
        set_cfg(2, 3, 2);
        pwm_cmd = 1'b1;
        capture(1, 1);
        set_cfg(9, 9, 9);
        capture(2, 12);
        chk("R9 burst pos cycles unchanged", cnt_pos(2, 11), 3);
        chk("R9 steady time unchanged", int'(pos_s[12]), 1);
        set_cfg(2, 3, 2);
    endtask

    task automatic t_bidir_rise();
        set_level(1'b0);
        mode_uni = 1'b0;
        pwm_cmd = 1'b1;
        capture(1, 13);
        chk("R3 bidir pos cycles", cnt_pos(2, 12), 2);
        chk("R4 bidir neg gap cycles", cnt_neg(2, 12), 4);
        chk("R2 bidir swap idle", int'(pos_s[4]) + int'(neg_s[4]), 0);
        chk("R3 bidir steady", int'(pos_s[13]), 1);
    endtask

    task automatic t_fall_disabled();
        set_level(1'b1);
        en_fall = 1'b0;
        pwm_cmd = 1'b0;
        capture(1, 3);
        chk("R6 fall pass idle", int'(pos_s[2]) + int'(neg_s[2]), 0);
        chk("R6 fall pass neg", int'(neg_s[3]), 1);
    endtask

    task automatic t_fall_enabled();
        set_level(1'b1);
        en_fall = 1'b1;
        mode_uni = 1'b1;
        pwm_cmd = 1'b0;
        capture(1, 12);
        chk("R6 uni fall neg cycles", cnt_neg(2, 11), 3);
        chk("R5 uni fall pos cycles", cnt_pos(2, 11), 0);
        chk("R6 uni fall steady", int'(neg_s[12]), 1);
        en_fall = 1'b0;
    endtask

    task automatic t_abort();
        set_level(1'b0);
        mode_uni = 1'b0;
        set_cfg(10, 10, 4);
        pwm_cmd = 1'b1;
        capture(1, 3);
        pwm_cmd = 1'b0;
        capture(4, 40);
        chk("R8 neg after abort", int'(neg_s[6]), 1);
        chk("R8 no pos after abort", cnt_pos(6, 40), 0);
        chk("R8 neg held after abort", cnt_neg(6, 40), 35);
        set_cfg(2, 3, 2);
    endtask

    task automatic t_zero_cfg();
        set_level(1'b0);
        set_cfg(2, 3, 0);
        pwm_cmd = 1'b1;
        capture(1, 12);
        chk("R10 zero count passes", cnt_pos(3, 12), 10);
        set_cfg(2, 3, 2);
    endtask

    task automatic t_clear();
        set_level(1'b0);
        spike_clear = 1'b1;
        step();
        spike_clear = 1'b0;
        pwm_cmd = 1'b1;
        capture(1, 12);
        chk("R7 cleared idle", int'(pos_s[2]) + int'(neg_s[2]), 0);
        chk("R7 cleared passes", cnt_pos(3, 12), 10);
    endtask

    initial begin
        rst_n = 1'b0; pwm_cmd = 1'b0; spike_async = 1'b0; spike_clear = 1'b0;
        mode_uni = 1'b0; en_rise = 1'b1; en_fall = 1'b1;
        set_cfg(2, 3, 2);
        @(negedge clk);
        t_reset();
        t_pass();
        t_arm();
        en_fall = 1'b0;
        t_uni_rise();
        t_cfg_hold();
        t_bidir_rise();
        t_fall_disabled();
        t_fall_enabled();
        t_abort();
        t_zero_cfg();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule